// File: doc/BRIEF.md
# Configurable CD-DSP Serial Data Receiver

This block receives the serial audio-format data stream that an external CD digital signal processor emits and turns it into parallel 16-bit words. The stream consists of a bit clock, a left/right word clock, serial data, a C2 error flag and an emphasis flag. Each pin is brought into the faster system clock domain through a two-stage synchronizer. Edges are detected on the synchronized bit clock and word clock, and the data bits are assembled from there.

Four static configuration inputs adapt the receiver to different processor output formats. They select a 24- or 32-clock slot per channel, LSB-first or MSB-first ordering, data placed at the start or at the end of the slot, and sampling on the rising or the falling bit-clock edge. Every finished word leaves through a valid/ready output. It carries its channel, the C2 flag and the emphasis flag. Two sticky status outputs report slots that were too short and words that were replaced before the consumer accepted them. The consumer is the next stage of a CD-ROM data path. Sector sync, descrambling and error correction belong to that stage and are not done here.

Top module: `cdsp_serial_rx`

## Requirements
- R1: After reset, `out_valid`, `frame_err` and `overflow` are 0.
- R2: With a 32-clock slot (`cfg_slot24`=0), front packing (`cfg_rear`=0), MSB-first order (`cfg_msb_first`=1) and rising-edge sampling (`cfg_fall_edge`=0), the first 16 sampled bits of a slot form the word. The first sampled bit is bit 15. A word is presented on `out_valid`/`out_data` once its last bit has been sampled.
- R3: With `cfg_msb_first`=0, the first sampled data bit of the word becomes bit 0 and the last becomes bit 15.
- R4: With `cfg_rear`=1, the data bits are the last 16 bit periods of the configured slot. For a slot length S these are bit periods S-16 to S-1, counted from 0 after the word-clock transition. The earlier periods are ignored.
- R5: With `cfg_slot24`=1, the configured slot length is 24 bit periods. This length is used for rear placement.
- R6: With `cfg_fall_edge`=1, data, C2 and emphasis are sampled on falling bit-clock edges instead of rising ones.
- R7: Every transition of the word clock starts a new slot. `out_left` equals the word-clock level after that transition, so 1 means left.
- R8: `out_err` is the C2 flag level sampled at the same bit-clock edge as the word's last data bit.
- R9: `out_emph` is the emphasis flag level sampled at the same edge as the word's last data bit.
- R10: Bit periods after the 16 data bits of a slot are ignored, including periods beyond the configured slot length. They neither change the word nor produce another word.
- R11: A slot that ends with a word-clock transition before its word is complete produces no word. It sets `frame_err`, which stays 1 until reset.
- R12: If a new word completes while a presented word has not been accepted (`out_valid`=1 and `out_ready`=0), the new word replaces it and `overflow` becomes 1 and stays 1 until reset.
- R13: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1, and `out_data` changes only when a newer word replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_bck | input | 1 | Serial bit clock from the DSP |
| pin_lrck | input | 1 | Left/right word clock; high selects left |
| pin_sd | input | 1 | Serial data |
| pin_c2 | input | 1 | C2 error flag |
| pin_emph | input | 1 | Emphasis flag |
| cfg_slot24 | input | 1 | 1: 24-period slot, 0: 32-period slot |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_rear | input | 1 | 1: data at end of slot, 0: at start |
| cfg_fall_edge | input | 1 | 1: sample on falling edge, 0: on rising edge |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Assembled data word |
| out_left | output | 1 | Channel of the word, 1 = left |
| out_err | output | 1 | C2 flag attached to the word |
| out_emph | output | 1 | Emphasis flag attached to the word |
| frame_err | output | 1 | Sticky: a slot ended before its word was complete |
| overflow | output | 1 | Sticky: an unaccepted word was replaced |

## Verification
The assertions check the output handshake and the status flags on every cycle. They cover validity holding under backpressure, a stable word until a replacement arrives, the sticky nature of both status flags, overflow being raised by a replacement, and a completed word reaching the output one cycle later with the assembled bits unchanged. What a word should contain is another matter. The bit order, the placement within the slot, the slot length, the sampling edge, the channel and the exact instant at which C2 and emphasis are taken all depend on serial stimulus. Only the bench scenarios show these: they sweep all sixteen format combinations and compare against words computed arithmetically, and they also exercise short and overlong slots and a stalled consumer.

// File: rtl/cdrx_pkg.sv
package cdrx_pkg;
    localparam int unsigned WORD_W = 16;

    // Pin positions inside the synchronizer vector.
    localparam int unsigned PIN_BCK  = 0;
    localparam int unsigned PIN_LRCK = 1;
    localparam int unsigned PIN_SD   = 2;
    localparam int unsigned PIN_C2   = 3;
    localparam int unsigned PIN_EMPH = 4;
    localparam int unsigned N_PINS   = 5;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              left;
        logic              err;
        logic              emph;
    } rx_word_t;
endpackage

// File: rtl/cdrx_sync.sv
module cdrx_sync #(
    parameter int unsigned N      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);
    logic [N-1:0][STAGES-1:0] pipe_d, pipe_q;

    for (genvar g = 0; g < N; g++) begin : g_pin
        if (STAGES == 1) begin : g_one
            always_comb pipe_d[g] = pin_i[g];
        end else begin : g_many
            always_comb pipe_d[g] = {pipe_q[g][STAGES-2:0], pin_i[g]};
        end
        assign lvl_o[g] = pipe_q[g][STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end
endmodule

// File: rtl/cdrx_edge.sv
module cdrx_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    for (genvar g = 0; g < N; g++) begin : g_det
        assign rise_o[g] =  lvl_i[g] & ~prev_q[g];
        assign fall_o[g] = ~lvl_i[g] &  prev_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/cdrx_deser.sv
module cdrx_deser
    import cdrx_pkg::*;
#(
    parameter int unsigned LONG_SLOT  = 32,
    parameter int unsigned SHORT_SLOT = 24
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bck_rise_i,
    input  logic     bck_fall_i,
    input  logic     lr_edge_i,
    input  logic     lr_lvl_i,
    input  logic     sd_i,
    input  logic     c2_i,
    input  logic     emph_i,
    input  logic     cfg_slot24_i,
    input  logic     cfg_msb_i,
    input  logic     cfg_rear_i,
    input  logic     cfg_fall_i,
    output logic     push_o,
    output rx_word_t word_o,
    output logic     fe_set_o
);
    localparam int unsigned CNT_W   = $clog2(LONG_SLOT) + 2;
    localparam int          CNT_SAT = (1 << CNT_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              active;
        logic              done;
        logic              left;
    } deser_t;

    deser_t st_d, st_q;
    logic   strobe;
    logic   open_slot;
    int     slot_len;
    int     win_lo;
    int     pos;
    int     k;
    int     idx;

    always_comb begin
        st_d      = st_q;
        push_o    = 1'b0;
        fe_set_o  = 1'b0;
        k         = 0;
        idx       = 0;
        strobe    = cfg_fall_i ? bck_fall_i : bck_rise_i;
        slot_len  = cfg_slot24_i ? int'(SHORT_SLOT) : int'(LONG_SLOT);
        win_lo    = cfg_rear_i ? (slot_len - int'(WORD_W)) : 0;
        pos       = int'(st_q.cnt);
        open_slot = st_q.active;

        // A word-clock transition closes the slot and opens the next one.
        if (lr_edge_i) begin
            fe_set_o    = st_q.active & ~st_q.done;
            st_d.active = 1'b1;
            st_d.done   = 1'b0;
            st_d.left   = lr_lvl_i;
            st_d.shreg  = '0;
            st_d.cnt    = '0;
            pos         = 0;
            open_slot   = 1'b1;
        end

        if (strobe && open_slot && (pos < CNT_SAT)) begin
            st_d.cnt = CNT_W'(pos + 1);
            if ((pos >= win_lo) && (pos < win_lo + int'(WORD_W))) begin
                k   = pos - win_lo;
                idx = cfg_msb_i ? (int'(WORD_W) - 1 - k) : k;
                st_d.shreg[idx] = sd_i;
                if (k == int'(WORD_W) - 1) begin
                    push_o    = 1'b1;
                    st_d.done = 1'b1;
                end
            end
        end

        word_o.data = st_d.shreg;
        word_o.left = st_d.left;
        word_o.err  = c2_i;
        word_o.emph = emph_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cdrx_outbuf.sv
module cdrx_outbuf
    import cdrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  rx_word_t word_i,
    input  logic     fe_set_i,
    input  logic     ready_i,
    output logic     valid_o,
    output rx_word_t word_o,
    output logic     ovf_o,
    output logic     ferr_o
);
    typedef struct packed {
        logic     valid;
        rx_word_t word;
        logic     ovf;
        logic     ferr;
    } obuf_t;

    obuf_t ob_d, ob_q;

    always_comb begin
        ob_d = ob_q;
        if (ob_q.valid && ready_i) ob_d.valid = 1'b0;
        if (push_i) begin
            if (ob_q.valid && !ready_i) ob_d.ovf = 1'b1;
            ob_d.valid = 1'b1;
            ob_d.word  = word_i;
        end
        if (fe_set_i) ob_d.ferr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ob_q <= '0;
        else        ob_q <= ob_d;
    end

    assign valid_o = ob_q.valid;
    assign word_o  = ob_q.word;
    assign ovf_o   = ob_q.ovf;
    assign ferr_o  = ob_q.ferr;
endmodule

// File: rtl/cdsp_serial_rx.sv
module cdsp_serial_rx
    import cdrx_pkg::*;
#(
    parameter int unsigned LONG_SLOT   = 32,
    parameter int unsigned SHORT_SLOT  = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_bck,
    input  logic              pin_lrck,
    input  logic              pin_sd,
    input  logic              pin_c2,
    input  logic              pin_emph,
    input  logic              cfg_slot24,
    input  logic              cfg_msb_first,
    input  logic              cfg_rear,
    input  logic              cfg_fall_edge,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_left,
    output logic              out_err,
    output logic              out_emph,
    output logic              frame_err,
    output logic              overflow
);
    logic [N_PINS-1:0] pins_raw;
    logic [N_PINS-1:0] pins_lvl;
    logic [1:0]        clk_lvl, clk_rise, clk_fall;
    logic              lr_edge;
    logic              push;
    logic              fe_set;
    rx_word_t          push_word;
    rx_word_t          held_word;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_BCK]  = pin_bck;
        pins_raw[PIN_LRCK] = pin_lrck;
        pins_raw[PIN_SD]   = pin_sd;
        pins_raw[PIN_C2]   = pin_c2;
        pins_raw[PIN_EMPH] = pin_emph;
    end

    cdrx_sync #(.N(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pins_raw),
        .lvl_o (pins_lvl)
    );

    assign clk_lvl = {pins_lvl[PIN_LRCK], pins_lvl[PIN_BCK]};

    cdrx_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (clk_lvl),
        .rise_o (clk_rise),
        .fall_o (clk_fall)
    );

    assign lr_edge = clk_rise[1] | clk_fall[1];

    cdrx_deser #(.LONG_SLOT(LONG_SLOT), .SHORT_SLOT(SHORT_SLOT)) u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .bck_rise_i   (clk_rise[0]),
        .bck_fall_i   (clk_fall[0]),
        .lr_edge_i    (lr_edge),
        .lr_lvl_i     (clk_lvl[1]),
        .sd_i         (pins_lvl[PIN_SD]),
        .c2_i         (pins_lvl[PIN_C2]),
        .emph_i       (pins_lvl[PIN_EMPH]),
        .cfg_slot24_i (cfg_slot24),
        .cfg_msb_i    (cfg_msb_first),
        .cfg_rear_i   (cfg_rear),
        .cfg_fall_i   (cfg_fall_edge),
        .push_o       (push),
        .word_o       (push_word),
        .fe_set_o     (fe_set)
    );

    cdrx_outbuf u_obuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push),
        .word_i   (push_word),
        .fe_set_i (fe_set),
        .ready_i  (out_ready),
        .valid_o  (out_valid),
        .word_o   (held_word),
        .ovf_o    (overflow),
        .ferr_o   (frame_err)
    );

    assign out_data = held_word.data;
    assign out_left = held_word.left;
    assign out_err  = held_word.err;
    assign out_emph = held_word.emph;
endmodule

// File: rtl/cdrx_checker.sv
module cdrx_checker
    import cdrx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              push,
    input logic [WORD_W-1:0] push_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              frame_err,
    input logic              overflow
);
    p_valid_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    p_data_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !push) |=> $stable(out_data));

    p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (out_valid && out_data == $past(push_data)));

    p_frame_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_ovf_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && out_valid && !out_ready) |=> overflow);
endmodule

bind cdsp_serial_rx cdrx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_word.data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .frame_err (frame_err),
    .overflow  (overflow)
);

// File: tb/sim_cdsp_serial_rx.sv
`timescale 1ns/1ps
module sim_cdsp_serial_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_bck = 1'b0, pin_lrck = 1'b0, pin_sd = 1'b0, pin_c2 = 1'b0, pin_emph = 1'b0;
    logic cfg_slot24 = 1'b0, cfg_msb_first = 1'b1, cfg_rear = 1'b0, cfg_fall_edge = 1'b0;
    logic out_valid, out_ready;
    logic [15:0] out_data;
    logic out_left, out_err, out_emph, frame_err, overflow;

    always #2 clk = ~clk;

    cdsp_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .pin_bck(pin_bck), .pin_lrck(pin_lrck),
        .pin_sd(pin_sd), .pin_c2(pin_c2), .pin_emph(pin_emph),
        .cfg_slot24(cfg_slot24), .cfg_msb_first(cfg_msb_first),
        .cfg_rear(cfg_rear), .cfg_fall_edge(cfg_fall_edge),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_left(out_left), .out_err(out_err), .out_emph(out_emph),
        .frame_err(frame_err), .overflow(overflow)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [15:0] exp_data [0:15];
    logic        exp_left [0:15];
    logic        exp_err  [0:15];
    logic        exp_emph [0:15];
    int          exp_n;
    logic [15:0] got_data [0:15];
    logic        got_left [0:15];
    logic        got_err  [0:15];
    logic        got_emph [0:15];
    int          got_n;
    logic        lr_lvl;

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && got_n < 16) begin
            got_data[got_n] = out_data;
            got_left[got_n] = out_left;
            got_err[got_n]  = out_err;
            got_emph[got_n] = out_emph;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        pin_lrck = 1'b0;
        lr_lvl   = 1'b0;
        pin_bck  = cfg_fall_edge;
        pin_sd   = 1'b0;
        pin_c2   = 1'b0;
        pin_emph = 1'b0;
        got_n    = 0;
        exp_n    = 0;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    // One slot: toggle the word clock, then nbits bit periods.
    task automatic send_slot(input logic [15:0] w, input bit c2v, input bit emv,
                             input int nbits);
        int slen;
        int lo;
        slen   = cfg_slot24 ? 24 : 32;
        lo     = cfg_rear ? slen - 16 : 0;
        lr_lvl = ~lr_lvl;
        pin_lrck = lr_lvl;
        if (nbits >= lo + 16 && exp_n < 16) begin
            exp_data[exp_n] = w;
            exp_left[exp_n] = lr_lvl;
            exp_err[exp_n]  = c2v;
            exp_emph[exp_n] = emv;
            exp_n++;
        end
        for (int p = 0; p < nbits; p++) begin
            int k;
            k = p - lo;
            if (k >= 0 && k < 16) pin_sd = cfg_msb_first ? w[15-k] : w[k];
            else                  pin_sd = p[0] ^ p[2];   // filler, must be ignored (R10)
            pin_c2   = (k == 15) ? c2v : ~c2v;
            pin_emph = (k == 15) ? emv : ~emv;
            repeat (4) @(posedge clk);
            pin_bck = ~cfg_fall_edge;
            repeat (4) @(posedge clk);
            pin_bck = cfg_fall_edge;
        end
    endtask

    task automatic compare(input string dreq);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(got_n == exp_n, dreq, "word count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_data[i] == exp_data[i], dreq, "data", got_data[i], exp_data[i]);
            chk(got_left[i] == exp_left[i], "R7", "channel", got_left[i], exp_left[i]);
            chk(got_err[i]  == exp_err[i],  "R8", "c2 flag", got_err[i], exp_err[i]);
            chk(got_emph[i] == exp_emph[i], "R9", "emphasis", got_emph[i], exp_emph[i]);
        end
    endtask

    initial begin
        out_ready = 1'b1;
        got_n = 0;
        exp_n = 0;
        lr_lvl = 1'b0;

        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        chk(frame_err == 1'b0, "R1", "frame_err after reset", frame_err, 0);
        chk(overflow  == 1'b0, "R1", "overflow after reset", overflow, 0);

        // Sweep all format combinations (R2..R9)
        for (int c = 0; c < 16; c++) begin
            string tag;
            cfg_slot24    = c[0];
            cfg_msb_first = ~c[1];
            cfg_rear      = c[2];
            cfg_fall_edge = c[3];
            if (c[0])       tag = "R5";
            else if (c[2])  tag = "R4";
            else if (c[3])  tag = "R6";
            else if (c[1])  tag = "R3";
            else            tag = "R2";
            do_reset();
            for (int s = 0; s < 4; s++) begin
                logic [15:0] w;
                w = 16'h9C35 ^ 16'(c * 16'h1357) ^ 16'(s * 16'h2468);
                send_slot(w, s[0] ^ c[0], s[1], cfg_slot24 ? 24 : 32);
            end
            compare(tag);
            chk(frame_err == 1'b0, "R11", "no frame error on full slots", frame_err, 0);
            chk(overflow == 1'b0, "R12", "no overflow when ready", overflow, 0);
        end

        // R10: overlong slots, extra periods beyond the slot ignored
        cfg_slot24 = 1'b0; cfg_msb_first = 1'b1; cfg_rear = 1'b0; cfg_fall_edge = 1'b0;
        do_reset();
        send_slot(16'h1234, 1'b1, 1'b0, 40);
        send_slot(16'hFEDC, 1'b0, 1'b1, 40);
        compare("R10");
        chk(frame_err == 1'b0, "R10", "frame_err on long slot", frame_err, 0);

        // R11: short slot yields no word and sticky frame error
        do_reset();
        send_slot(16'hAAAA, 1'b0, 1'b0, 10);
        exp_n = 0;   // the short slot is never expected
        send_slot(16'h5A3C, 1'b1, 1'b1, 32);
        compare("R11");
        chk(frame_err == 1'b1, "R11", "frame_err after short slot", frame_err, 1);
        send_slot(16'h0F0F, 1'b0, 1'b0, 32);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(frame_err == 1'b1, "R11", "frame_err sticky", frame_err, 1);

        // R12/R13: stalled consumer, second word replaces the first
        do_reset();
        out_ready = 1'b0;
        send_slot(16'h1111, 1'b0, 1'b0, 32);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b1, "R13", "valid held under stall", out_valid, 1);
        chk(out_data == 16'h1111, "R13", "data held under stall", out_data, 16'h1111);
        chk(overflow == 1'b0, "R12", "no overflow yet", overflow, 0);
        send_slot(16'h2222, 1'b1, 1'b0, 32);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(overflow == 1'b1, "R12", "overflow set", overflow, 1);
        chk(out_data == 16'h2222, "R12", "newer word presented", out_data, 16'h2222);
        chk(out_left == 1'b0, "R7", "channel of newer word", out_left, 0);
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R13", "valid drops after accept", out_valid, 0);
        chk(overflow == 1'b1, "R12", "overflow sticky", overflow, 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule